// File: doc/BRIEF.md
# Serial ADC Register Configuration Sequencer

This block brings an external analog-to-digital converter into a known register setup after every system reset. It first holds the converter's hardware reset pin high, with the serial enable also high, so that the converter's serial registers return to their defaults. It then drops the reset pin for good and writes a short, parameter-defined list of register settings over a three-wire serial link. The three wires are an active-low enable, a data line and a serial clock.

Two counters step through the list. An address counter picks the register address byte and advances once the address half of a frame has gone out. A data counter picks the value byte and advances when the whole frame is complete. Each write is one 16-bit frame. The serial clock is the system clock divided by a parameter. The enable line returns high for one serial clock period between frames. After the last write the block stays quiet and raises `done` until the next system reset.

Top module: `adc_cfg_seq`

## Requirements
- R1: While `rst` is high, `adc_reset` and `adc_sen` are both 1. After release, `adc_reset` stays 1 for exactly RST_CYCLES clock cycles, counting the cycle in which `rst` is first low.
- R2: After the reset phase, `adc_reset` is 0 with `adc_sen` 1 for exactly CLK_DIV cycles before the first frame. `adc_reset` stays 0 until the next `rst`, and is never 1 while `adc_sen` is 0.
- R3: During each frame `adc_sen` is 0 for exactly 16*CLK_DIV cycles, and `adc_sclk` shows exactly 16 rising edges.
- R4: Frame i carries ADDR_TABLE[8i+7:8i] followed by DATA_TABLE[8i+7:8i], 16 bits MSB first. Each bit is taken at a rising edge of `adc_sclk`.
- R5: `adc_sdata` does not change while `adc_sclk` stays high. It changes only while the clock is low.
- R6: `adc_sclk` is 0 whenever `adc_sen` is 1. Within a frame its period is CLK_DIV cycles, and it is high for CLK_DIV - CLK_DIV/2 cycles of each period, starting low.
- R7: Between consecutive frames `adc_sen` is 1 for exactly CLK_DIV cycles.
- R8: Exactly NUM_REGS frames are sent, in table order, entry 0 first.
- R9: `done` is 0 until the last frame has ended. It then becomes 1 and stays 1 with `adc_sen`=1, `adc_reset`=0 and `adc_sclk`=0 until the next `rst`.
- R10: Asserting `rst` in the middle of a frame aborts it at once. The next release restarts the full sequence from R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| adc_reset | output | 1 | Converter hardware reset pin |
| adc_sen | output | 1 | Serial enable, active low |
| adc_sclk | output | 1 | Serial clock, idles low |
| adc_sdata | output | 1 | Serial data, MSB first |
| done | output | 1 | Configuration complete |

## Verification
Several properties are checked on every cycle:
- the serial clock stays low while the enable is high;
- the reset pin stays low while a frame is active;
- the data line holds still across each high clock phase;
- `done`, once raised, stays raised with the link quiet;
- the two counters never drift more than one entry apart.

Other behaviour only the bench scenarios can show, by decoding the link at the pins:
- the exact reset-phase and gap lengths;
- the frame length and the number of clock edges;
- the bit-accurate content and order of every frame;
- the restart after a reset that arrives in the middle of a frame.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;

    localparam int ADDR_W  = 8;
    localparam int DATA_W  = 8;
    localparam int FRAME_W = ADDR_W + DATA_W;

    typedef enum logic [1:0] {
        ST_RESET = 2'd0,
        ST_GAP   = 2'd1,
        ST_SHIFT = 2'd2,
        ST_IDLE  = 2'd3
    } seq_state_e;

    // first member is the MSB, so the address byte goes out first
    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } cfg_frame_t;

    typedef struct packed {
        logic reset_pin;
        logic sen_pin;
    } pin_pair_t;

    function automatic pin_pair_t pins_for(seq_state_e st);
        pin_pair_t p;
        case (st)
            ST_RESET: p = '{reset_pin: 1'b1, sen_pin: 1'b1};
            ST_SHIFT: p = '{reset_pin: 1'b0, sen_pin: 1'b0};
            default:  p = '{reset_pin: 1'b0, sen_pin: 1'b1};
        endcase
        return p;
    endfunction

endpackage

// File: rtl/adcseq_delay.sv
module adcseq_delay #(
    parameter int INIT_LEN   = 4,
    parameter int RELOAD_LEN = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic expire
);
    localparam int MAXL = (INIT_LEN > RELOAD_LEN) ? INIT_LEN : RELOAD_LEN;
    localparam int CW   = $clog2(MAXL + 1);

    logic [CW-1:0] cnt;
    logic          busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= CW'(INIT_LEN - 1);
            busy <= 1'b1;
        end else if (start) begin
            cnt  <= CW'(RELOAD_LEN - 1);
            busy <= 1'b1;
        end else if (busy) begin
            if (cnt == '0) busy <= 1'b0;
            else           cnt  <= cnt - 1'b1;
        end
    end

    assign expire = busy && (cnt == '0);

    // R7
    restart_load_chk: assert property (@(posedge clk) disable iff (rst)
        start |=> (busy && cnt == CW'(RELOAD_LEN - 1)));
endmodule

// File: rtl/adcseq_bitclk.sv
module adcseq_bitclk #(
    parameter int CLK_DIV = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic adv,
    output logic sclk
);
    localparam int PW   = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
    localparam int HALF = CLK_DIV / 2;

    logic [PW-1:0] ph;

    always_ff @(posedge clk) begin
        if (rst || !run)                 ph <= '0;
        else if (ph == PW'(CLK_DIV - 1)) ph <= '0;
        else                             ph <= ph + 1'b1;
    end

    assign adv  = run && (ph == PW'(CLK_DIV - 1));
    assign sclk = run && (ph >= PW'(HALF));

    // R6
    period_low_start_chk: assert property (@(posedge clk) disable iff (rst)
        adv |=> !sclk);
endmodule

// File: rtl/adcseq_shifter.sv
module adcseq_shifter
    import adcseq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  cfg_frame_t frame,
    input  logic       adv,
    output logic       sdata,
    output logic       addr_done,
    output logic       frame_done
);
    localparam int BW = $clog2(FRAME_W);

    logic [FRAME_W-1:0] sreg;
    logic [BW-1:0]      bitcnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            sreg   <= '0;
            bitcnt <= '0;
        end else if (load) begin
            sreg   <= frame;
            bitcnt <= '0;
        end else if (adv) begin
            sreg   <= {sreg[FRAME_W-2:0], 1'b0};
            bitcnt <= bitcnt + 1'b1;
        end
    end

    assign sdata      = sreg[FRAME_W-1];
    assign addr_done  = adv && (bitcnt == BW'(ADDR_W - 1));
    assign frame_done = adv && (bitcnt == BW'(FRAME_W - 1));

    // R4
    load_msb_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> (sdata == $past(frame.addr[ADDR_W-1])));
endmodule

// File: rtl/adc_cfg_seq.sv
module adc_cfg_seq
    import adcseq_pkg::*;
#(
    parameter int CLK_DIV    = 4,
    parameter int RST_CYCLES = 4,
    parameter int NUM_REGS   = 4,
    parameter logic [NUM_REGS*ADDR_W-1:0] ADDR_TABLE = 32'h3D25_1400,
    parameter logic [NUM_REGS*DATA_W-1:0] DATA_TABLE = 32'hA501_8002
) (
    input  logic clk,
    input  logic rst,
    output logic adc_reset,
    output logic adc_sen,
    output logic adc_sclk,
    output logic adc_sdata,
    output logic done
);
    localparam int CW = $clog2(NUM_REGS + 1);

    seq_state_e    state, state_n;
    logic [CW-1:0] a_cnt, d_cnt;
    logic          gap_done, tmr_start, shift_load;
    logic          bit_adv, sclk_int, sdata_int, addr_done, frame_done;
    cfg_frame_t    next_frame;
    pin_pair_t     pins;

    adcseq_delay #(.INIT_LEN(RST_CYCLES), .RELOAD_LEN(CLK_DIV)) u_dly (
        .clk(clk), .rst(rst), .start(tmr_start), .expire(gap_done));

    adcseq_bitclk #(.CLK_DIV(CLK_DIV)) u_bclk (
        .clk(clk), .rst(rst), .run(state == ST_SHIFT),
        .adv(bit_adv), .sclk(sclk_int));

    adcseq_shifter u_shf (
        .clk(clk), .rst(rst), .load(shift_load), .frame(next_frame),
        .adv(bit_adv), .sdata(sdata_int),
        .addr_done(addr_done), .frame_done(frame_done));

    always_comb begin
        next_frame.addr = ADDR_TABLE[int'(a_cnt)*ADDR_W +: ADDR_W];
        next_frame.data = DATA_TABLE[int'(d_cnt)*DATA_W +: DATA_W];
    end

    always_comb begin
        state_n    = state;
        tmr_start  = 1'b0;
        shift_load = 1'b0;
        case (state)
            ST_RESET: if (gap_done) begin
                state_n   = ST_GAP;
                tmr_start = 1'b1;
            end
            ST_GAP: if (gap_done) begin
                if (a_cnt == CW'(NUM_REGS)) begin
                    state_n = ST_IDLE;
                end else begin
                    state_n    = ST_SHIFT;
                    shift_load = 1'b1;
                end
            end
            ST_SHIFT: if (frame_done) begin
                state_n   = ST_GAP;
                tmr_start = 1'b1;
            end
            default: state_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_RESET;
            a_cnt <= '0;
            d_cnt <= '0;
        end else begin
            state <= state_n;
            if (addr_done)  a_cnt <= a_cnt + 1'b1;
            if (frame_done) d_cnt <= d_cnt + 1'b1;
        end
    end

    assign pins      = pins_for(state);
    assign adc_reset = pins.reset_pin;
    assign adc_sen   = pins.sen_pin;
    assign adc_sclk  = sclk_int;
    assign adc_sdata = (state == ST_SHIFT) ? sdata_int : 1'b0;
    assign done      = (state == ST_IDLE);

    // R6
    sclk_idle_chk: assert property (@(posedge clk) disable iff (rst)
        adc_sen |-> !adc_sclk);

    // R2
    reset_low_in_frame_chk: assert property (@(posedge clk) disable iff (rst)
        !adc_sen |-> !adc_reset);

    // R5
    sdata_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (adc_sclk && $past(adc_sclk)) |-> $stable(adc_sdata));

    // R9
    done_hold_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> done);

    // R9
    done_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (adc_sen && !adc_reset && !adc_sclk));

    // R8
    counter_order_chk: assert property (@(posedge clk) disable iff (rst)
        (d_cnt <= a_cnt) && (a_cnt <= d_cnt + 1'b1));
endmodule

// File: tb/adc_cfg_seq_tb_top.sv
`timescale 1ns/1ps
module adc_cfg_seq_tb_top;
    localparam int DIV  = 6;
    localparam int RSTC = 3;
    localparam int NUM  = 4;
    localparam logic [31:0] ADDR_T = 32'h3D25_1400;
    localparam logic [31:0] DATA_T = 32'hA501_8002;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic adc_reset, adc_sen, adc_sclk, adc_sdata, done;

    always #4 clk = ~clk;

    adc_cfg_seq #(.CLK_DIV(DIV), .RST_CYCLES(RSTC), .NUM_REGS(NUM),
                  .ADDR_TABLE(ADDR_T), .DATA_TABLE(DATA_T)) dut_i (
        .clk(clk), .rst(rst), .adc_reset(adc_reset), .adc_sen(adc_sen),
        .adc_sclk(adc_sclk), .adc_sdata(adc_sdata), .done(done));

    int checks = 0;
    int fails  = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int exp_frame(input int i);
        return int'({ADDR_T[i*8 +: 8], DATA_T[i*8 +: 8]});
    endfunction

    task automatic test_reset_state();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk(adc_reset == 1'b1, "R1 reset pin during rst", int'(adc_reset), 1);
        chk(adc_sen == 1'b1, "R1 sen during rst", int'(adc_sen), 1);
        chk(adc_sclk == 1'b0, "R6 sclk during rst", int'(adc_sclk), 0);
        chk(done == 1'b0, "R9 done during rst", int'(done), 0);
    endtask

    // releases rst at the current negedge and decodes the whole sequence
    task automatic observe_sequence(input string tag);
        int rst_hi = 0, reset_again = 0, lead_gap = -1, gap = 0, gap_min = 1000000;
        int fidx = 0, nbits = 0, low_len = 0, hi_len = 0, last_rise = -1;
        int per_bad = 0, stab_bad = 0, idle_sclk = 0, cyc = 0;
        bit seen_drop = 0, got_done = 0;
        logic [15:0] sh = '0;
        logic p_sclk = 1'b0, p_sen = 1'b1, p_sd = 1'b0;
        logic r, s, c, d;
        rst = 1'b0;
        while (!got_done && cyc < 20000) begin
            if (cyc > 0) @(negedge clk);
            r = adc_reset; s = adc_sen; c = adc_sclk; d = adc_sdata;
            if (r) begin
                if (seen_drop) reset_again++;
                else           rst_hi++;
            end else begin
                seen_drop = 1;
            end
            if (s && c) idle_sclk++;
            if (!s) begin
                if (p_sen) begin
                    if (fidx == 0) lead_gap = gap;
                    else if (gap < gap_min) gap_min = gap;
                    low_len = 0; hi_len = 0; nbits = 0; sh = '0; last_rise = -1;
                end
                low_len++;
                if (c) hi_len++;
                if (c && !p_sclk) begin
                    sh = {sh[14:0], d};
                    nbits++;
                    if (last_rise >= 0 && cyc - last_rise != DIV) per_bad++;
                    last_rise = cyc;
                end
                if (c && p_sclk && d != p_sd) stab_bad++;
            end else begin
                if (!p_sen) begin
                    chk(low_len == 16*DIV, {"R3 frame length ", tag}, low_len, 16*DIV);
                    chk(nbits == 16, {"R3 sclk rising edges ", tag}, nbits, 16);
                    chk(hi_len == 16*(DIV - DIV/2), {"R6 sclk high time ", tag},
                        hi_len, 16*(DIV - DIV/2));
                    if (fidx < NUM)
                        chk(int'(sh) == exp_frame(fidx), {"R4 frame content ", tag},
                            int'(sh), exp_frame(fidx));
                    else
                        chk(1'b0, {"R8 extra frame ", tag}, fidx + 1, NUM);
                    fidx++;
                    gap = 0;
                end
                if (!r) gap++;
            end
            if (done) begin
                got_done = 1;
                chk(fidx == NUM, {"R8 frames before done ", tag}, fidx, NUM);
            end
            p_sclk = c; p_sen = s; p_sd = d;
            cyc++;
        end
        chk(got_done, {"R9 done reached ", tag}, int'(got_done), 1);
        chk(rst_hi == RSTC, {"R1 reset phase length ", tag}, rst_hi, RSTC);
        chk(reset_again == 0, {"R2 reset pin stays low ", tag}, reset_again, 0);
        chk(lead_gap == DIV, {"R2 reset-low phase length ", tag}, lead_gap, DIV);
        chk(gap_min == DIV, {"R7 inter-frame gap ", tag}, gap_min, DIV);
        chk(idle_sclk == 0, {"R6 sclk while sen high ", tag}, idle_sclk, 0);
        chk(stab_bad == 0, {"R5 sdata change while sclk high ", tag}, stab_bad, 0);
        chk(per_bad == 0, {"R6 sclk period ", tag}, per_bad, 0);
    endtask

    task automatic test_idle_hold();
        int bad = 0;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (!done || !adc_sen || adc_reset || adc_sclk) bad++;
        end
        chk(bad == 0, "R9 idle holds", bad, 0);
    endtask

    task automatic test_restart();
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        repeat (RSTC + DIV + 40) @(negedge clk);
        chk(adc_sen == 1'b0, "R10 frame in progress before abort", int'(adc_sen), 0);
        rst = 1'b1;
        @(negedge clk);
        chk(adc_reset == 1'b1, "R10 reset pin after abort", int'(adc_reset), 1);
        chk(adc_sen == 1'b1, "R10 sen after abort", int'(adc_sen), 1);
        chk(adc_sclk == 1'b0, "R10 sclk after abort", int'(adc_sclk), 0);
        chk(done == 1'b0, "R10 done after abort", int'(done), 0);
        @(negedge clk);
        observe_sequence("after restart R10");
    endtask

    initial begin
        test_reset_state();
        observe_sequence("first run");
        test_idle_hold();
        test_restart();
        test_idle_hold();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL R9 watchdog: actual %0d expected %0d", 0, 1);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule